// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the software-facing side of a UART. A 32-bit register bus reads and writes a small word-addressed register window. A byte-wide receive input feeds an eight-entry queue, and a transmit strobe carries bytes out. Serial timing, baud generation and flow control live elsewhere. The control register gates reception with a baud-clock enable bit and sets a receive threshold. The status word is built on the fly from the queue occupancy. An interrupt-flag register is cleared by writing ones. A single level interrupt line goes high whenever an enabled flag is set.

Reads are combinational: `bus_rdata` is valid in the same cycle that `bus_sel` is high with `bus_wr` low. Side effects take place at the closing clock edge: a pop on a data-register read, and the register update and flags on a write. Registers sit on 32-bit word boundaries. An address with its two low bits non-zero, or beyond the last register, is unmapped.

Top module: `uart_csr_front`

## Requirements
- R1: A receive byte is taken only when `rx_valid` is high, the baud-clock enable (control bit 15) is set and the queue holds fewer than 8 bytes. `rx_ready` shows exactly this condition. A byte offered at any other time is lost.
- R2: When a byte is taken, flag bit 4 (receive threshold) is set if the occupancy after that edge is at least control bits 3:0.
- R3: `irq` is high exactly when some bit of the flag register (0x0C) ANDed with the enable register (0x08) is 1. It follows every push, pop and flag change on the next edge.
- R4: A write to the flag register clears every flag bit written as 1 and keeps the bits written as 0.
- R5: A control write with bit 5 set empties the queue and also discards a byte offered in that same cycle. Bits 5 and 4 always read back as 0.
- R6: A control write with bit 15 set stores bit 19 (clock ready) as 1. Other bits are stored as written.
- R7: The status register (0x04) reads the occupancy in bits 11:8, bit 6 always 1, and bit 4 set when the queue is empty. All other bits are 0, and writes to it change nothing.
- R8: A read of the data register (0x20) returns the oldest byte and removes it. A read of the peek register (0x18) returns the oldest byte and keeps it. Both read 0 when the queue is empty.
- R9: A write to the data register puts `bus_wdata[7:0]` on `tx_byte` with `tx_valid` high for the next cycle, and sets flag bit 6 (transmit half-empty).
- R10: After reset, control, enable, flags, clock divider, oversampling, DMA and both wakeup registers read 0. The pin register reads 0x2, with bit 1 as RTS. The queue is empty, so status reads 0x50.
- R11: Clock divider 0x10, oversampling 0x14, pin 0x1C, DMA 0x24, wakeup enable 0x28 and wakeup flag 0x2C store full 32-bit words. Unmapped addresses read 0 and writes to them are lost. Writes to the peek register are lost.
- R12: In one cycle, a push with a data-register pop leaves the occupancy unchanged and returns the old head. A flag clear and a set event on the same bit leave that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_valid | input | 1 | Receive byte offered |
| rx_byte | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte would be taken |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The receive port and the register bus run independently, so a byte can arrive in the same cycle that software pops the data register, flushes the queue or clears flags. The random phase drives `rx_valid` together with bus accesses in most cycles. Directed cases force three collisions: push with pop on a part-full queue, push with flush, and a threshold push while the same flag bit is being cleared. Each case is judged against a bench model that applies pop before push, flush over both, and set over clear. Occupancy, head byte and `irq` are compared after every edge.

// File: rtl/ucsr_pkg.sv
package ucsr_pkg;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam int BW = 8;

  localparam int CTRL_CLKEN  = 15;
  localparam int CTRL_CLKRDY = 19;
  localparam int CTRL_TXFL   = 4;
  localparam int CTRL_RXFL   = 5;
  localparam int THR_W       = 4;
  localparam int ST_TXEMPTY  = 6;
  localparam int ST_RXEMPTY  = 4;
  localparam int ST_LVL_LSB  = 8;
  localparam int ST_LVL_W    = 4;
  localparam int FLG_RXTHR   = 4;
  localparam int FLG_TXHE    = 6;
  localparam int PIN_RTS     = 1;
  localparam int NUM_PLAIN   = 6;

  typedef enum logic [3:0] {
    SEL_CTRL   = 4'd0,  SEL_STATUS = 4'd1,  SEL_IEN    = 4'd2,  SEL_FLAGS = 4'd3,
    SEL_CLKDIV = 4'd4,  SEL_OSR    = 4'd5,  SEL_PEEK   = 4'd6,  SEL_PIN   = 4'd7,
    SEL_DATA   = 4'd8,  SEL_DMA    = 4'd9,  SEL_WKEN   = 4'd10, SEL_WKFL  = 4'd11,
    SEL_NONE   = 4'd15
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(logic [AW-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      case (a[AW-1:2])
        8'd0:  s = SEL_CTRL;
        8'd1:  s = SEL_STATUS;
        8'd2:  s = SEL_IEN;
        8'd3:  s = SEL_FLAGS;
        8'd4:  s = SEL_CLKDIV;
        8'd5:  s = SEL_OSR;
        8'd6:  s = SEL_PEEK;
        8'd7:  s = SEL_PIN;
        8'd8:  s = SEL_DATA;
        8'd9:  s = SEL_DMA;
        8'd10: s = SEL_WKEN;
        8'd11: s = SEL_WKFL;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

  // index of a plain storage register, NUM_PLAIN when not one
  function automatic int plain_index(reg_sel_e s);
    case (s)
      SEL_CLKDIV: return 0;
      SEL_OSR:    return 1;
      SEL_PIN:    return 2;
      SEL_DMA:    return 3;
      SEL_WKEN:   return 4;
      SEL_WKFL:   return 5;
      default:    return NUM_PLAIN;
    endcase
  endfunction

  function automatic logic [DW-1:0] plain_reset(int idx);
    return (idx == 2) ? (DW'(1) << PIN_RTS) : '0;
  endfunction

  function automatic logic [DW-1:0] ctrl_on_write(logic [DW-1:0] w);
    logic [DW-1:0] v;
    v = w;
    v[CTRL_TXFL] = 1'b0;
    v[CTRL_RXFL] = 1'b0;
    if (w[CTRL_CLKEN]) v[CTRL_CLKRDY] = 1'b1;
    return v;
  endfunction

  function automatic logic [DW-1:0] status_word(int unsigned lvl, logic empty);
    logic [DW-1:0] v;
    v = '0;
    v[ST_LVL_LSB +: ST_LVL_W] = ST_LVL_W'(lvl);
    v[ST_TXEMPTY] = 1'b1;
    v[ST_RXEMPTY] = empty;
    return v;
  endfunction

  function automatic logic thr_met(int unsigned lvl, int unsigned thr);
    return lvl >= thr;
  endfunction

  // clear first, then new events: a same-cycle event wins
  function automatic logic [DW-1:0] flags_next(logic [DW-1:0] cur, logic clr_en,
                                               logic [DW-1:0] clr_mask,
                                               logic [DW-1:0] set_mask);
    logic [DW-1:0] v;
    v = clr_en ? (cur & ~clr_mask) : cur;
    return v | set_mask;
  endfunction
endpackage

// File: rtl/ucsr_rx_fifo.sv
module ucsr_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = empty ? '0 : mem[rd_ptr];

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/ucsr_flag_unit.sv
module ucsr_flag_unit
  import ucsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  input  logic [DW-1:0] set_mask,
  input  logic [DW-1:0] ien,
  output logic [DW-1:0] flags,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_next(flags, clr_en, clr_mask, set_mask);
  end

  assign irq = |(flags & ien);
endmodule

// File: rtl/ucsr_plain_regs.sv
module ucsr_plain_regs
  import ucsr_pkg::*;
#(
  parameter int N = NUM_PLAIN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  int                   wr_idx,
  input  logic [DW-1:0]        wdata,
  output logic [N-1:0][DW-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    q[i] <= plain_reset(i);
      else if (wr_en && wr_idx == i) q[i] <= wdata;
    end
  end
endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
  import ucsr_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  localparam int CW      = $clog2(RX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [9:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic          irq
);
  reg_sel_e            sel;
  logic                rd_en, wr_en;
  logic [DW-1:0]       ctrl_q, ien_q, flags_q;
  logic [CW-1:0]       fifo_count, cnt_after;
  logic                fifo_empty, fifo_full;
  logic [BW-1:0]       fifo_head;
  logic                push_fire, pop_fire, flush_fire;
  logic                thr_fire, txw_fire, flag_clr_fire;
  logic [DW-1:0]       set_mask;
  logic [NUM_PLAIN-1:0][DW-1:0] plain_q;
  int                  plain_idx;

  assign sel           = decode_addr(bus_addr);
  assign rd_en         = bus_sel && !bus_wr;
  assign wr_en         = bus_sel && bus_wr;
  assign flush_fire    = wr_en && sel == SEL_CTRL && bus_wdata[CTRL_RXFL];
  assign rx_ready      = ctrl_q[CTRL_CLKEN] && !fifo_full;
  assign push_fire     = rx_valid && rx_ready && !flush_fire;
  assign pop_fire      = rd_en && sel == SEL_DATA && !fifo_empty && !flush_fire;
  assign txw_fire      = wr_en && sel == SEL_DATA;
  assign flag_clr_fire = wr_en && sel == SEL_FLAGS;
  assign cnt_after     = fifo_count + CW'(push_fire) - CW'(pop_fire);
  assign thr_fire      = push_fire && thr_met(int'(cnt_after), int'(ctrl_q[THR_W-1:0]));
  assign plain_idx     = plain_index(sel);

  always_comb begin
    set_mask = '0;
    set_mask[FLG_RXTHR] = thr_fire;
    set_mask[FLG_TXHE]  = txw_fire;
  end

  ucsr_rx_fifo #(.DEPTH(RX_DEPTH), .W(BW)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_fire),
    .pop   (pop_fire),
    .flush (flush_fire),
    .din   (rx_byte),
    .head  (fifo_head),
    .count (fifo_count),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  ucsr_flag_unit i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (flag_clr_fire),
    .clr_mask (bus_wdata),
    .set_mask (set_mask),
    .ien      (ien_q),
    .flags    (flags_q),
    .irq      (irq)
  );

  ucsr_plain_regs #(.N(NUM_PLAIN)) i_plain (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en && plain_idx < NUM_PLAIN),
    .wr_idx (plain_idx),
    .wdata  (bus_wdata),
    .q      (plain_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      if (wr_en && sel == SEL_CTRL) ctrl_q <= ctrl_on_write(bus_wdata);
      if (wr_en && sel == SEL_IEN)  ien_q  <= bus_wdata;
      tx_valid <= txw_fire;
      if (txw_fire) tx_byte <= bus_wdata[BW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_CTRL:   bus_rdata = ctrl_q;
        SEL_STATUS: bus_rdata = status_word(int'(fifo_count), fifo_empty);
        SEL_IEN:    bus_rdata = ien_q;
        SEL_FLAGS:  bus_rdata = flags_q;
        SEL_PEEK,
        SEL_DATA:   bus_rdata = DW'(fifo_head);
        SEL_CLKDIV: bus_rdata = plain_q[0];
        SEL_OSR:    bus_rdata = plain_q[1];
        SEL_PIN:    bus_rdata = plain_q[2];
        SEL_DMA:    bus_rdata = plain_q[3];
        SEL_WKEN:   bus_rdata = plain_q[4];
        SEL_WKFL:   bus_rdata = plain_q[5];
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ucsr_checker.sv
module ucsr_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        tx_valid,
  input logic        irq,
  input logic [31:0] bus_wdata,
  input logic [31:0] ctrl_q,
  input logic [31:0] ien_q,
  input logic [31:0] flags_q,
  input logic [CW-1:0] fifo_count,
  input logic        push_fire,
  input logic        pop_fire,
  input logic        flush_fire,
  input logic        thr_fire,
  input logic        txw_fire,
  input logic        flag_clr_fire
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) int'(fifo_count) <= DEPTH); // R1
  AST_CLKOFF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !ctrl_q[15] && !pop_fire && !flush_fire) |=> fifo_count == $past(fifo_count)); // R1
  AST_THR_SET: assert property (@(posedge clk) disable iff (!rst_n) (push_fire && !pop_fire && (int'(fifo_count) + 1 >= int'(ctrl_q[3:0]))) |=> flags_q[4]); // R2
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) irq == ((flags_q & ien_q) != 32'd0)); // R3
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr_fire && !txw_fire && !thr_fire) |=> (flags_q & $past(bus_wdata)) == 32'd0); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush_fire |=> fifo_count == '0); // R5
  AST_FLUSH_BITS: assert property (@(posedge clk) disable iff (!rst_n) ctrl_q[5:4] == 2'b00); // R5
  AST_CLK_READY: assert property (@(posedge clk) disable iff (!rst_n) ctrl_q[15] |-> ctrl_q[19]); // R6
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n) (pop_fire && !push_fire) |=> fifo_count == $past(fifo_count) - 1'b1); // R8
  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n) txw_fire |=> (tx_valid && flags_q[6])); // R9
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (pop_fire && push_fire) |=> $stable(fifo_count)); // R12
endmodule

bind uart_csr_front ucsr_checker #(.DEPTH(RX_DEPTH), .CW(CW)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_valid      (rx_valid),
  .tx_valid      (tx_valid),
  .irq           (irq),
  .bus_wdata     (bus_wdata),
  .ctrl_q        (ctrl_q),
  .ien_q         (ien_q),
  .flags_q       (flags_q),
  .fifo_count    (fifo_count),
  .push_fire     (push_fire),
  .pop_fire      (pop_fire),
  .flush_fire    (flush_fire),
  .thr_fire      (thr_fire),
  .txw_fire      (txw_fire),
  .flag_clr_fire (flag_clr_fire)
);

// File: tb/test_uart_csr_front.sv
`timescale 1ns/1ps
module test_uart_csr_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_byte;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  uart_csr_front i_uart_csr_front (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  // bench model
  logic [7:0]  mq[$];
  logic [31:0] m_ctrl, m_ien, m_flg, m_clkdiv, m_osr, m_pin, m_dma, m_wken, m_wkfl;

  function automatic void model_reset();
    mq.delete();
    m_ctrl = 0; m_ien = 0; m_flg = 0; m_clkdiv = 0; m_osr = 0;
    m_pin = 32'h2; m_dma = 0; m_wken = 0; m_wkfl = 0;
  endfunction

  function automatic logic [31:0] head_or_zero();
    return (mq.size() == 0) ? 32'd0 : {24'd0, mq[0]};
  endfunction

  function automatic logic [31:0] exp_read(logic [9:0] a);
    case (a)
      10'h000: return m_ctrl;
      10'h004: return (32'(mq.size()) << 8) | 32'h40 | ((mq.size() == 0) ? 32'h10 : 32'h0);
      10'h008: return m_ien;
      10'h00C: return m_flg;
      10'h010: return m_clkdiv;
      10'h014: return m_osr;
      10'h018: return head_or_zero();
      10'h01C: return m_pin;
      10'h020: return head_or_zero();
      10'h024: return m_dma;
      10'h028: return m_wken;
      10'h02C: return m_wkfl;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(logic [9:0] a);
    case (a)
      10'h000: return "R6";
      10'h004: return "R7";
      10'h008: return "R3";
      10'h00C: return "R4";
      10'h018, 10'h020: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle: optional bus access and optional receive offer
  task automatic cyc(input bit bv, input bit bw, input logic [9:0] a, input logic [31:0] d,
                     input bit rv, input logic [7:0] rb, input string tg);
    bit ready_pre, pushing, popping, flushing, txw, thr;
    @(negedge clk);
    bus_sel = bv; bus_wr = bw; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_byte = rb;
    #5;
    if (bv && !bw) check(bus_rdata == exp_read(a), (tg == "") ? req_of(a) : tg, bus_rdata, exp_read(a));
    ready_pre = m_ctrl[15] && mq.size() < 8;
    check(rx_ready == ready_pre, "R1", 32'(rx_ready), 32'(ready_pre));
    flushing = bv && bw && a == 10'h000 && d[5];
    pushing  = rv && ready_pre && !flushing;
    popping  = bv && !bw && a == 10'h020 && mq.size() > 0 && !flushing;
    txw      = bv && bw && a == 10'h020;
    @(posedge clk);
    #1;
    if (flushing) mq.delete();
    if (popping) void'(mq.pop_front());
    if (pushing) mq.push_back(rb);
    thr = pushing && (mq.size() >= int'(m_ctrl[3:0]));
    if (bv && bw && a == 10'h00C) m_flg = m_flg & ~d;
    if (thr) m_flg[4] = 1'b1;
    if (txw) m_flg[6] = 1'b1;
    if (bv && bw) begin
      case (a)
        10'h000: m_ctrl = (d & ~32'h30) | (d[15] ? 32'h80000 : 32'h0);
        10'h008: m_ien = d;
        10'h010: m_clkdiv = d;
        10'h014: m_osr = d;
        10'h01C: m_pin = d;
        10'h024: m_dma = d;
        10'h028: m_wken = d;
        10'h02C: m_wkfl = d;
        default: ;
      endcase
    end
    check(tx_valid == txw, "R9", 32'(tx_valid), 32'(txw));
    if (txw) check(tx_byte == d[7:0], "R9", 32'(tx_byte), 32'(d[7:0]));
    check(irq == ((m_flg & m_ien) != 0), "R3", 32'(irq), 32'((m_flg & m_ien) != 0));
  endtask

  task automatic rd(input logic [9:0] a, input string tg);
    cyc(1, 0, a, 0, 0, 0, tg);
  endtask
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, 0, 0, "");
  endtask
  task automatic rx(input logic [7:0] b);
    cyc(0, 0, 0, 0, 1, b, "");
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] seed;
    model_reset();
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset values
    for (int a = 0; a <= 'h2C; a += 4) rd(10'(a), "R10");
    check(irq == 1'b0, "R10", 32'(irq), 0);

    // R1 bytes ignored with clock disabled
    rx(8'hAA); rx(8'hBB);
    rd(10'h004, "R1");

    // R6 / R5 control write side effects, threshold 3
    wr(10'h000, 32'h0000_8033);
    rd(10'h000, "R6");
    wr(10'h008, 32'h10);
    rx(8'h11); rx(8'h22);
    rd(10'h00C, "R2");
    rx(8'h33);
    rd(10'h00C, "R2");
    rd(10'h018, "R8"); rd(10'h018, "R8");
    rd(10'h020, "R8");
    rd(10'h004, "R7");
    // R12 push with pop in one cycle
    cyc(1, 0, 10'h020, 0, 1, 8'h44, "R12");
    rd(10'h004, "R12");
    // fill to full, extra byte dropped (R1)
    for (int i = 0; i < 8; i++) rx(8'h50 + 8'(i));
    rd(10'h004, "R1");
    // R12 flag clear with a same-cycle threshold set
    cyc(1, 1, 10'h00C, 32'h10, 0, 0, "");
    rd(10'h020, "R8");
    cyc(1, 1, 10'h00C, 32'h10, 1, 8'h77, "R12");
    rd(10'h00C, "R12");
    // R9 transmit, R4 selective clear
    wr(10'h020, 32'hDEAD_BEA5);
    wr(10'h00C, 32'h40);
    rd(10'h00C, "R4");
    // R7 status write ignored, R11 unmapped and peek writes
    wr(10'h004, 32'hFFFF_FFFF); rd(10'h004, "R7");
    wr(10'h018, 32'h1234); rd(10'h018, "R11");
    wr(10'h030, 32'hFFFF); rd(10'h030, "R11");
    wr(10'h011, 32'h5); rd(10'h011, "R11"); rd(10'h010, "R11");
    // R5 flush with a same-cycle push
    cyc(1, 1, 10'h000, 32'h0000_8021, 1, 8'h99, "R5");
    rd(10'h004, "R5"); rd(10'h020, "R8"); rd(10'h000, "R5");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [9:0] a;
      logic [31:0] d;
      bit rv;
      k  = $urandom_range(0, 99);
      rv = ($urandom_range(0, 99) < 55);
      d  = $urandom();
      a  = 10'($urandom_range(0, 12) * 4);
      if (k < 30)      cyc(1, 0, 10'h020, 0, rv, 8'($urandom()), "");
      else if (k < 40) cyc(1, 0, 10'h004, 0, rv, 8'($urandom()), "");
      else if (k < 45) cyc(1, 1, 10'h000, (d & 32'hFFFF_7FDF) | ($urandom_range(0, 3) != 0 ? 32'h8000 : 0) | ($urandom_range(0, 19) == 0 ? 32'h20 : 0), rv, 8'($urandom()), "");
      else if (k < 52) cyc(1, 1, 10'h00C, d, rv, 8'($urandom()), "");
      else if (k < 56) cyc(1, 1, 10'h008, d & 32'h50, rv, 8'($urandom()), "");
      else if (k < 62) cyc(1, 1, 10'h020, d, rv, 8'($urandom()), "");
      else if (k < 75) cyc(1, 0, a, 0, rv, 8'($urandom()), "");
      else if (k < 80) cyc(1, 1, (a == 10'h000 || a == 10'h020) ? 10'h010 : a, d, rv, 8'($urandom()), "");
      else             cyc(0, 0, 0, 0, rv, 8'($urandom()), "");
    end
    @(negedge clk);
    bus_sel = 0; rx_valid = 0;
    summary();
  end
endmodule